// File: doc/BRIEF.md
# Outbound Address Window Translator

This block turns an address issued by the processor side into the address that goes out on the PCIe bus. It holds a set of programmable windows. Each window carries a 64-bit match value, a 64-bit mask, a 64-bit remap value and a 32-bit action word. A lookup compares the request address against every window at once. The lowest-numbered window that matches supplies the translated address and its action word. The action word tells the downstream issue logic whether to send a memory or an I/O transaction, along with any attribute bits.

Software sets the windows up through a simple word-wide register port. Bit 0 of a window's low match word is that window's enable. Software therefore fills in the remap, mask and action words first and writes the low match word with bit 0 set last. A global enable bit in a control word turns translation on for all windows. A per-request bypass input turns it off for a single lookup. When no window applies, the address leaves unchanged, is marked as a miss, and carries an all-zero action word, which means memory type.

Top module: `obwin_xlate`

## Requirements
- R1: After synchronous reset, every window word and the control word read back as zero and `rsp_valid` is low.
- R2: The register port is word addressed. Window k occupies bytes k*0x20 .. k*0x20+0x1F:
  - +0x00 is match low and +0x04 is match high.
  - +0x08 is remap low and +0x0C is remap high.
  - +0x10 is mask low and +0x14 is mask high.
  - +0x18 is the action word.
  - The control word sits at N_WIN*0x20 and stores only bit 6, the global enable.
  - Writes to any other offset, or to an address with bits [1:0] not zero, change nothing, and such addresses read as zero.
- R3: A window hits when bit 0 of its match value is 1 and (addr & mask) == (match with bit 0 forced to 0) & mask. Match bit 0 is never compared.
- R4: On a hit, the translated address is (remap & mask) | (addr & ~mask).
- R5: When several windows hit, the lowest-numbered one is reported on `rsp_win` and supplies the address and action.
- R6: On a miss, `rsp_hit` is 0, `rsp_addr` equals the request address, `rsp_action` is 0 (memory type) and `rsp_win` is 0.
- R7: While the global enable is 0, every lookup behaves as a miss.
- R8: A lookup with `req_bypass` high behaves as a miss, whatever the windows hold.
- R9: Each lookup presented with `req_valid` high yields `rsp_valid` high, with its results, exactly one clock later. `rsp_valid` is low in any cycle that follows a cycle with no request.
- R10: On a hit, `rsp_action` is the window's action word unchanged. Bits [3:0] are the type (0x0 memory, 0x4 I/O), and the upper bits are attributes passed through.
- R11: A window whose enable bit is 0 never hits, even with an all-zero mask. Setting the bit makes it take part from the next lookup on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | REG_AW (9) | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_addr |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | 64 | Address to translate |
| req_bypass | input | 1 | Skip translation for this request |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | A window matched |
| rsp_win | output | WIN_IDX_W (3) | Index of the winning window |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_action | output | 32 | Action word of the winning window, zero on miss |

## Verification
A lookup result is due one clock after the edge that samples `req_valid`. The driver applies each request at a falling edge and pushes its expected result into a queue at the same moment. The monitor pops one entry at every later falling edge where `rsp_valid` is high, which is half a cycle after the registering edge. Register writes reach the lookup path in the cycle after the write edge, so every request is sent only after its setup writes have completed. Read data is combinational, so each readback is sampled shortly after the address is applied, still in the same cycle. Idle cycles are checked to show that no stray response appears.

// File: rtl/obwin_pkg.sv
package obwin_pkg;

    localparam int unsigned WIN_COUNT = 8;
    localparam int unsigned ADDR_W    = 64;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned WIN_BYTES = 32;
    localparam int unsigned GEN_BIT   = 6;

    // word slot inside one window block (byte offset / 4)
    typedef enum logic [2:0] {
        F_MATCH_LO = 3'd0,
        F_MATCH_HI = 3'd1,
        F_REMAP_LO = 3'd2,
        F_REMAP_HI = 3'd3,
        F_MASK_LO  = 3'd4,
        F_MASK_HI  = 3'd5,
        F_ACTION   = 3'd6,
        F_SPARE    = 3'd7
    } field_e;

    typedef struct packed {
        logic [ADDR_W-1:0] match;
        logic [ADDR_W-1:0] remap;
        logic [ADDR_W-1:0] mask;
        logic [WORD_W-1:0] action;
    } win_cfg_t;

    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] action;
    } xlate_t;

    function automatic logic [WORD_W-1:0] field_read(input win_cfg_t c, input field_e f);
        case (f)
            F_MATCH_LO: return c.match[31:0];
            F_MATCH_HI: return c.match[63:32];
            F_REMAP_LO: return c.remap[31:0];
            F_REMAP_HI: return c.remap[63:32];
            F_MASK_LO:  return c.mask[31:0];
            F_MASK_HI:  return c.mask[63:32];
            F_ACTION:   return c.action;
            default:    return '0;
        endcase
    endfunction

    function automatic logic win_match(input win_cfg_t c, input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] key;
        key = {c.match[ADDR_W-1:1], 1'b0};
        return c.match[0] && (((a ^ key) & c.mask) == '0);
    endfunction

    function automatic logic [ADDR_W-1:0] win_remap(input win_cfg_t c, input logic [ADDR_W-1:0] a);
        return (c.remap & c.mask) | (a & ~c.mask);
    endfunction

endpackage

// File: rtl/obwin_regs.sv
module obwin_regs
    import obwin_pkg::*;
#(
    parameter int unsigned N_WIN  = WIN_COUNT,
    parameter int unsigned REG_AW = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output win_cfg_t          cfg_o [N_WIN],
    output logic              gen_en_o
);
    localparam int unsigned SEL_W = REG_AW - 5;
    localparam logic [SEL_W-1:0] CTRL_SEL = SEL_W'(N_WIN);

    logic             aligned;
    logic [SEL_W-1:0] sel;
    field_e           fld;
    logic             ctrl_acc;
    win_cfg_t         cfg_q [N_WIN];
    logic             gen_q;

    assign aligned  = (addr[1:0] == 2'b00);
    assign sel      = addr[REG_AW-1:5];
    assign fld      = field_e'(addr[4:2]);
    assign ctrl_acc = aligned && (sel == CTRL_SEL) && (addr[4:2] == 3'd0);

    for (genvar i = 0; i < N_WIN; i++) begin : g_win
        logic wsel;
        assign wsel = wr_en && aligned && (sel == SEL_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[i] <= '0;
            end else if (wsel) begin
                case (fld)
                    F_MATCH_LO: cfg_q[i].match[31:0]  <= wdata;
                    F_MATCH_HI: cfg_q[i].match[63:32] <= wdata;
                    F_REMAP_LO: cfg_q[i].remap[31:0]  <= wdata;
                    F_REMAP_HI: cfg_q[i].remap[63:32] <= wdata;
                    F_MASK_LO:  cfg_q[i].mask[31:0]   <= wdata;
                    F_MASK_HI:  cfg_q[i].mask[63:32]  <= wdata;
                    F_ACTION:   cfg_q[i].action       <= wdata;
                    default:    ;
                endcase
            end
        end

        assign cfg_o[i] = cfg_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_q <= 1'b0;
        end else if (wr_en && ctrl_acc) begin
            gen_q <= wdata[GEN_BIT];
        end
    end

    assign gen_en_o = gen_q;

    always_comb begin
        rdata = '0;
        if (ctrl_acc) begin
            rdata[GEN_BIT] = gen_q;
        end
        for (int i = 0; i < N_WIN; i++) begin
            if (aligned && (sel == SEL_W'(i))) begin
                rdata = field_read(cfg_q[i], fld);
            end
        end
    end

endmodule

// File: rtl/obwin_cmp.sv
module obwin_cmp
    import obwin_pkg::*;
(
    input  win_cfg_t          cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] xaddr
);
    assign hit   = win_match(cfg, addr);
    assign xaddr = win_remap(cfg, addr);
endmodule

// File: rtl/obwin_pick.sv
module obwin_pick
    import obwin_pkg::*;
#(
    parameter int unsigned N_WIN     = WIN_COUNT,
    parameter int unsigned WIN_IDX_W = $clog2(N_WIN)
) (
    input  logic [N_WIN-1:0]     hits,
    input  logic [ADDR_W-1:0]    xaddrs  [N_WIN],
    input  logic [WORD_W-1:0]    actions [N_WIN],
    output xlate_t               res,
    output logic [WIN_IDX_W-1:0] win
);
    // scan from the top down so the lowest index is written last and wins
    always_comb begin
        res = '0;
        win = '0;
        for (int i = N_WIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                res.hit    = 1'b1;
                res.addr   = xaddrs[i];
                res.action = actions[i];
                win        = WIN_IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/obwin_xlate.sv
module obwin_xlate
    import obwin_pkg::*;
#(
    parameter  int unsigned N_WIN     = WIN_COUNT,
    localparam int unsigned REG_AW    = $clog2(N_WIN * WIN_BYTES) + 1,
    localparam int unsigned WIN_IDX_W = $clog2(N_WIN)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr_en,
    input  logic [REG_AW-1:0]    cfg_addr,
    input  logic [WORD_W-1:0]    cfg_wdata,
    output logic [WORD_W-1:0]    cfg_rdata,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_bypass,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic [WIN_IDX_W-1:0] rsp_win,
    output logic [ADDR_W-1:0]    rsp_addr,
    output logic [WORD_W-1:0]    rsp_action
);
    win_cfg_t             cfg   [N_WIN];
    logic                 glob_en;
    logic [N_WIN-1:0]     hits;
    logic [ADDR_W-1:0]    xaddrs  [N_WIN];
    logic [WORD_W-1:0]    actions [N_WIN];
    xlate_t               pick_res;
    logic [WIN_IDX_W-1:0] pick_win;
    xlate_t               res_d, res_q;
    logic [WIN_IDX_W-1:0] win_d, win_q;
    logic                 vld_q;

    obwin_regs #(.N_WIN(N_WIN), .REG_AW(REG_AW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr_en),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .cfg_o    (cfg),
        .gen_en_o (glob_en)
    );

    for (genvar i = 0; i < N_WIN; i++) begin : g_cmp
        obwin_cmp u_cmp (
            .cfg   (cfg[i]),
            .addr  (req_addr),
            .hit   (hits[i]),
            .xaddr (xaddrs[i])
        );
        assign actions[i] = cfg[i].action;
    end

    obwin_pick #(.N_WIN(N_WIN), .WIN_IDX_W(WIN_IDX_W)) u_pick (
        .hits    (hits),
        .xaddrs  (xaddrs),
        .actions (actions),
        .res     (pick_res),
        .win     (pick_win)
    );

    always_comb begin
        res_d = pick_res;
        win_d = pick_win;
        if (req_bypass || !glob_en || !pick_res.hit) begin
            res_d.hit    = 1'b0;
            res_d.addr   = req_addr;
            res_d.action = '0;
            win_d        = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
            win_q <= '0;
        end else begin
            vld_q <= req_valid;
            if (req_valid) begin
                res_q <= res_d;
                win_q <= win_d;
            end
        end
    end

    assign rsp_valid  = vld_q;
    assign rsp_hit    = res_q.hit;
    assign rsp_addr   = res_q.addr;
    assign rsp_action = res_q.action;
    assign rsp_win    = win_q;

endmodule

// File: rtl/obwin_xlate_chk.sv
module obwin_xlate_chk
    import obwin_pkg::*;
#(
    parameter int unsigned WIN_IDX_W = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic [ADDR_W-1:0]    req_addr,
    input logic                 req_bypass,
    input logic                 glob_en,
    input logic                 rsp_valid,
    input logic                 rsp_hit,
    input logic [WIN_IDX_W-1:0] rsp_win,
    input logic [ADDR_W-1:0]    rsp_addr,
    input logic [WORD_W-1:0]    rsp_action
);
    // R1
    rst_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rsp_valid);

    // R9
    resp_due_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R9
    no_stray_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R8
    bypass_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_bypass) |=> (!rsp_hit && rsp_addr == $past(req_addr)));

    // R7
    gen_off_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !glob_en) |=> (!rsp_hit && rsp_addr == $past(req_addr)));

    // R6
    miss_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_action == '0 && rsp_win == '0));
endmodule

bind obwin_xlate obwin_xlate_chk #(.WIN_IDX_W(WIN_IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_bypass (req_bypass),
    .glob_en    (glob_en),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_win    (rsp_win),
    .rsp_addr   (rsp_addr),
    .rsp_action (rsp_action)
);

// File: tb/obwin_xlate_test.sv
module obwin_xlate_test;
    localparam int NW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [8:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        req_bypass = 1'b0;
    logic        rsp_valid, rsp_hit;
    logic [2:0]  rsp_win;
    logic [63:0] rsp_addr;
    logic [31:0] rsp_action;

    int n_cmp = 0;
    int n_bad = 0;

    // shadow of the programmed windows
    logic [63:0] m_match [NW];
    logic [63:0] m_mask  [NW];
    logic [63:0] m_remap [NW];
    logic [31:0] m_act   [NW];
    logic        m_gen;

    // scoreboard queues
    logic        q_hit  [$];
    logic [2:0]  q_win  [$];
    logic [63:0] q_addr [$];
    logic [31:0] q_act  [$];
    string       q_tag  [$];

    always #5 clk = ~clk;

    obwin_xlate uut (
        .clk(clk), .rst(rst),
        .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_bypass(req_bypass),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_win(rsp_win),
        .rsp_addr(rsp_addr), .rsp_action(rsp_action)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        cfg_addr  = a;
        cfg_wdata = d;
        cfg_wr_en = 1'b1;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [8:0] a, input logic [31:0] exp);
        cfg_addr = a;
        #1;
        check(tag, 64'(cfg_rdata), 64'(exp));
        @(negedge clk);
    endtask

    task automatic set_win(input int w, input logic [63:0] mt, input logic [63:0] mk,
                           input logic [63:0] rm, input logic [31:0] ac);
        logic [8:0] b;
        b = 9'(w * 32);
        wr(b + 9'h04, mt[63:32]);
        wr(b + 9'h08, rm[31:0]);
        wr(b + 9'h0C, rm[63:32]);
        wr(b + 9'h10, mk[31:0]);
        wr(b + 9'h14, mk[63:32]);
        wr(b + 9'h18, ac);
        wr(b + 9'h00, mt[31:0]);
        m_match[w] = mt; m_mask[w] = mk; m_remap[w] = rm; m_act[w] = ac;
    endtask

    task automatic send(input logic [63:0] a, input logic byp, input string tag);
        logic        h;
        logic [2:0]  w;
        logic [63:0] xa;
        logic [31:0] ac;
        h = 1'b0; w = '0; xa = a; ac = '0;
        if (!byp && m_gen) begin
            for (int i = NW - 1; i >= 0; i--) begin
                if (m_match[i][0] &&
                    ((a & m_mask[i]) == ({m_match[i][63:1], 1'b0} & m_mask[i]))) begin
                    h  = 1'b1;
                    w  = 3'(i);
                    xa = (m_remap[i] & m_mask[i]) | (a & ~m_mask[i]);
                    ac = m_act[i];
                end
            end
        end
        q_hit.push_back(h); q_win.push_back(w); q_addr.push_back(xa);
        q_act.push_back(ac); q_tag.push_back(tag);
        req_valid  = 1'b1;
        req_addr   = a;
        req_bypass = byp;
        @(negedge clk);
        req_valid  = 1'b0;
        req_bypass = 1'b0;
    endtask

    task automatic drain();
        while (q_tag.size() != 0) @(negedge clk);
        // R9: nothing arrives after the last expected response
        @(negedge clk);
        check("R9 idle", 64'(rsp_valid), 64'd0);
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (q_tag.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R9 unexpected response actual=1 expected=0");
            end else begin
                string t;
                t = q_tag.pop_front();
                check({t, " hit"},    64'(rsp_hit),    64'(q_hit.pop_front()));
                check({t, " win"},    64'(rsp_win),    64'(q_win.pop_front()));
                check({t, " addr"},   rsp_addr,        q_addr.pop_front());
                check({t, " action"}, 64'(rsp_action), 64'(q_act.pop_front()));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) begin
            m_match[i] = '0; m_mask[i] = '0; m_remap[i] = '0; m_act[i] = '0;
        end
        m_gen = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        rd_check("R1 win0 match lo", 9'h000, 32'h0);
        rd_check("R1 win7 action",   9'h0F8, 32'h0);
        rd_check("R1 control",       9'h100, 32'h0);

        // R7: windows programmed but global enable off
        set_win(0, 64'h0000_0000_4000_0001, 64'hFFFF_FFFF_F800_0000,
                64'h0000_0010_E000_0000, 32'h0000_0000);
        send(64'h0000_0000_4123_4567, 1'b0, "R7 global off");
        drain();

        // R2 readback and control bit
        wr(9'h100, 32'hFFFF_FFFF); m_gen = 1'b1;
        rd_check("R2 control only bit 6", 9'h100, 32'h0000_0040);
        rd_check("R2 win0 remap hi", 9'h00C, 32'h0000_0010);
        rd_check("R2 win0 mask lo",  9'h010, 32'hF800_0000);
        wr(9'h03C, 32'hDEAD_BEEF);
        rd_check("R2 spare slot", 9'h03C, 32'h0);
        wr(9'h104, 32'hDEAD_BEEF);
        rd_check("R2 unmapped after control", 9'h104, 32'h0);
        wr(9'h019, 32'hDEAD_BEEF);
        rd_check("R2 misaligned ignored", 9'h018, 32'h0);

        // more windows: overlap on 2, I/O on 1, exact on 3, disabled catch-all on 4
        set_win(1, 64'h0000_0000_8000_0001, 64'hFFFF_FFFF_FFFF_0000,
                64'h0000_0000_0000_0000, 32'h0010_0004);
        set_win(2, 64'h0000_0000_4000_0001, 64'hFFFF_FFFF_F800_0000,
                64'h0000_0020_0000_0000, 32'h0010_0000);
        set_win(3, 64'h0000_0002_0000_1001, 64'hFFFF_FFFF_FFFF_FFFF,
                64'h0000_0000_0BAD_0000, 32'h0000_0004);
        set_win(4, 64'h0000_0000_0000_0000, 64'h0,
                64'h0, 32'h1234_5678);
        rd_check("R2 win3 action", 9'h078, 32'h0000_0004);
        rd_check("R2 win1 match lo", 9'h020, 32'h8000_0001);

        // back-to-back lookups (R9 each followed by its own response)
        send(64'h0000_0000_4123_4567, 1'b0, "R4 R5 win0 over win2");
        send(64'h0000_0000_8000_1234, 1'b0, "R10 io window");
        send(64'h0000_0002_0000_1000, 1'b0, "R3 match bit0 ignored");
        send(64'h0000_0002_0000_1001, 1'b0, "R3 addr bit0 compared");
        send(64'h0000_0000_C000_0000, 1'b0, "R6 miss");
        send(64'h0000_1234_0000_0000, 1'b0, "R11 disabled catch-all");
        send(64'h0000_0000_4000_0000, 1'b1, "R8 bypass");
        send(64'h0000_0000_47FF_FFFF, 1'b0, "R4 top of window");
        drain();

        // R11: enable window 4 now; takes everything not claimed lower
        wr(9'h080, 32'h0000_0001); m_match[4] = 64'h1;
        send(64'h0000_1234_0000_0000, 1'b0, "R11 enabled catch-all");
        send(64'h0000_0000_8000_00FF, 1'b0, "R5 win1 over win4");
        send(64'h0000_0000_C000_0000, 1'b1, "R8 bypass over catch-all");
        drain();

        // R7 again: global enable cleared
        wr(9'h100, 32'h0); m_gen = 1'b0;
        send(64'h0000_0000_8000_1234, 1'b0, "R7 disabled again");
        drain();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule